// File: doc/BRIEF.md
# Random Word Generator Peripheral with Warm-Up Discard

This peripheral turns a serial stream of entropy bits into 32-bit random words for software. Bits arrive on a one-bit input with a qualifying strobe. After the generator is switched on, a programmable number of leading bits is thrown away, because early output of a noise source tends to be biased. Every following group of 32 accepted bits becomes a word, and each word is written into a small output queue.

Software uses a short 32-bit register window. It loads the warm-up length and switches the generator on. It then polls the fill level shown in the top byte of the status word, or waits for the interrupt, and reads the data register once for each word it wants. Switching the generator off empties the queue and throws away any half-built word. The warm-up length remains loaded until software writes it again.

Top module: `rand_word_periph`

## Requirements
- R1: After reset the generator is off, the interrupt mask is clear, the queue is empty, the remaining warm-up count is zero, `data_irq` is low, and reads of the control, status, mask and data registers return 0.
- R2: A write to offset 0x0 sets the enable flag from write-data bit 0. All other written bits are ignored. A read of offset 0x0 returns the flag in bit 0 and zeros in every other bit.
- R3: A write to offset 0x4 loads the warm-up count from write-data bits [19:0]. While enabled, each strobed entropy bit decrements a nonzero count by one, and that bit is discarded.
- R4: While enabled and the warm-up count is zero, strobed bits are gathered most significant bit first. The 32nd bit completes a word, which enters the queue at that clock edge.
- R5: A read of offset 0x4 returns the queue fill level in bits [31:24] and the remaining warm-up count in bits [19:0]. Bits [23:20] read as zero.
- R6: A read of offset 0x8 returns the oldest queued word and removes it. Back-to-back reads return the words in the order they arrived.
- R7: A read of offset 0x8 with an empty queue returns 0 and leaves the fill level at 0.
- R8: The queue holds 16 words. A word that completes while the queue is full is dropped, the fill level stays at 16, and the words already queued are kept.
- R9: While the enable flag is 0, the queue is held empty and any partly gathered word is cleared.
- R10: While disabled, the warm-up count keeps its value (unless it is rewritten), and strobed entropy bits have no effect.
- R11: Offset 0x10 bit 0 is the interrupt mask and reads back in bit 0. `data_irq` is high exactly when the fill level is nonzero and the mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of the data offset pops the queue at the edge |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| noise_bit | input | 1 | Entropy bit |
| noise_vld | input | 1 | Marks `noise_bit` as a fresh sample |
| data_irq | output | 1 | Data-available interrupt |

## Verification
The bench sweeps the warm-up length over 0 to 6. For each length it sends exactly that many ones before a known word, so an off-by-one discard count shows up as a shifted word on readback. It fills the queue past 16 words. A design that wrapped its pointers would lose the oldest words or report a small count. A design that overwrote stored words would return the wrong data. The bench also reads the data register while the queue is empty; a design that underflows returns stale data or a wrapped count. It disables the generator in the middle of a word and checks the next word. A design that keeps the partial bits, or keeps queued data, returns a misaligned word or a nonzero count. Finally it sends entropy while disabled and toggles the mask, so a warm-up count that moves while off, or an interrupt that ignores the mask, is caught at the ports.

// File: rtl/rwp_pkg.sv
package rwp_pkg;
   localparam int WORD_W       = 32;
   localparam int OFS_CTRL     = 'h00;
   localparam int OFS_STAT     = 'h04;
   localparam int OFS_DATA     = 'h08;
   localparam int OFS_MASK     = 'h10;
   localparam int STAT_CNT_LSB = 24;
   localparam int STAT_CNT_W   = 8;
endpackage

// File: rtl/rwp_collector.sv
module rwp_collector import rwp_pkg::*; #(
   parameter int WARM_W    = 20,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              warm_ld,
   input  logic [WARM_W-1:0] warm_ld_val,
   input  logic              bit_in,
   input  logic              bit_vld,
   output logic [WARM_W-1:0] warm,
   output logic              push,
   output logic [WORD_W-1:0] word
);
   localparam int BCNT_W = $clog2(WORD_W);

   logic [WORD_W-1:0] shreg, shreg_nx;
   logic [BCNT_W-1:0] bcnt;
   logic              warming, accept;

   assign warming = (warm != '0);
   assign accept  = en && bit_vld && !warming;
   assign push    = accept && (bcnt == BCNT_W'(WORD_W-1));
   assign word    = shreg_nx;

   generate
      if (MSB_FIRST) begin : g_msb
         assign shreg_nx = {shreg[WORD_W-2:0], bit_in};
      end else begin : g_lsb
         assign shreg_nx = {bit_in, shreg[WORD_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warm <= '0;
      end else if (warm_ld) begin
         warm <= warm_ld_val;
      end else if (en && bit_vld && warming) begin
         warm <= warm - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         bcnt  <= '0;
      end else if (!en) begin
         shreg <= '0;
         bcnt  <= '0;
      end else if (accept) begin
         shreg <= shreg_nx;
         bcnt  <= bcnt + 1'b1;
      end
   end
endmodule

// File: rtl/rwp_fifo.sv
module rwp_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push,
   input  logic [W-1:0]               wdata,
   input  logic                       pop,
   output logic [W-1:0]               rdata,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       empty
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH+1);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             full, do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/rand_word_periph.sv
module rand_word_periph import rwp_pkg::*; #(
   parameter int FIFO_DEPTH = 16,
   parameter int WARM_W     = 20,
   parameter int ADDR_W     = 5,
   parameter bit MSB_FIRST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              noise_bit,
   input  logic              noise_vld,
   output logic              data_irq
);
   localparam int CNT_W = $clog2(FIFO_DEPTH+1);

   generate
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH-1)) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two of at least 2");
      end
      if (CNT_W > STAT_CNT_W) begin : g_bad_cnt
         $error("fill level does not fit the status count field");
      end
      if (WARM_W < 1 || WARM_W > STAT_CNT_LSB - 4) begin : g_bad_warm
         $error("WARM_W must lie in 1..20");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must reach the mask offset");
      end
   endgenerate

   logic              sel_ctrl, sel_stat, sel_data, sel_mask;
   logic              en_q, mask_q;
   logic [WARM_W-1:0] warm;
   logic              push, pop, fifo_empty;
   logic [WORD_W-1:0] word, head;
   logic [CNT_W-1:0]  fill;
   logic [31:0]       stat_word;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata;

   assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
   assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
   assign sel_data = (bus_addr == ADDR_W'(OFS_DATA));
   assign sel_mask = (bus_addr == ADDR_W'(OFS_MASK));
   assign pop      = bus_rd && sel_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mask_q <= 1'b0;
      end else if (bus_wr) begin
         if (sel_ctrl) en_q   <= bus_wdata[0];
         if (sel_mask) mask_q <= bus_wdata[0];
      end
   end

   rwp_collector #(.WARM_W(WARM_W), .MSB_FIRST(MSB_FIRST)) u_coll (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en_q),
      .warm_ld     (bus_wr && sel_stat),
      .warm_ld_val (bus_wdata[WARM_W-1:0]),
      .bit_in      (noise_bit),
      .bit_vld     (noise_vld),
      .warm        (warm),
      .push        (push),
      .word        (word)
   );

   rwp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (!en_q),
      .push  (push),
      .wdata (word),
      .pop   (pop),
      .rdata (head),
      .count (fill),
      .empty (fifo_empty)
   );

   always_comb begin
      stat_word = '0;
      stat_word[STAT_CNT_LSB +: STAT_CNT_W] = STAT_CNT_W'(fill);
      stat_word[WARM_W-1:0] = warm;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (sel_ctrl)                 bus_rdata = {31'b0, en_q};
         else if (sel_stat)            bus_rdata = stat_word;
         else if (sel_data && !fifo_empty) bus_rdata = head;
         else if (sel_mask)            bus_rdata = {31'b0, mask_q};
      end
   end

   assign data_irq = !fifo_empty && !mask_q;
endmodule

// File: rtl/rwp_chk.sv
module rwp_chk #(
   parameter int DEPTH  = 16,
   parameter int WARM_W = 20,
   parameter int ADDR_W = 5,
   parameter int CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata,
   input logic              data_irq,
   input logic              en_q,
   input logic              mask_q,
   input logic [WARM_W-1:0] warm,
   input logic              push,
   input logic [CNT_W-1:0]  fill
);
   logic rd_data, wr_stat;
   assign rd_data = bus_rd && (bus_addr == ADDR_W'(8));
   assign wr_stat = bus_wr && (bus_addr == ADDR_W'(4));

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CNT_W'(DEPTH));

   // R9
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> fill == '0);

   // R10
   warm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !wr_stat) |=> $stable(warm));

   // R7
   empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && fill == '0) |-> bus_rdata == 32'h0);

   // R7
   empty_read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && fill == '0 && !push) |=> fill == '0);

   // R3
   warm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> warm == '0);

   // R11
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q |-> !data_irq);
endmodule

bind rand_word_periph rwp_chk #(
   .DEPTH(FIFO_DEPTH), .WARM_W(WARM_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_rwp_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .data_irq(data_irq),
   .en_q(en_q), .mask_q(mask_q), .warm(warm), .push(push), .fill(fill)
);

// File: tb/tb_rand_word_periph.sv
module tb_rand_word_periph;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        noise_bit = 1'b0, noise_vld = 1'b0;
   logic        data_irq;

   int n_chk = 0, n_bad = 0;
   int seq = 0;
   bit enabled = 0;
   logic [31:0] expq [$];

   always #2 clk = ~clk;

   rand_word_periph dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .noise_bit(noise_bit), .noise_vld(noise_vld), .data_irq(data_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      if (a == 5'h00) begin
         enabled = d[0];
         if (!d[0]) expq.delete();
      end
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic send_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk);
         noise_vld = 1'b1; noise_bit = v[i];
      end
      @(negedge clk);
      noise_vld = 1'b0;
   endtask

   function automatic logic [31:0] gen(input int k);
      return (32'h9E3779B9 * (k + 1)) ^ 32'h5A5A0F0F;
   endfunction

   task automatic send_word(output logic [31:0] w);
      w = gen(seq);
      seq++;
      send_bits(w, 32);
      if (enabled && expq.size() < 16) expq.push_back(w);
   endtask

   task automatic drain(input string req);
      logic [31:0] d;
      while (expq.size() > 0) begin
         rd(5'h08, d);
         chk(req, d, expq.pop_front());
      end
   endtask

   initial begin
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d, w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq", {31'b0, data_irq}, 32'h0);
      rd(5'h00, d); chk("R1 ctrl", d, 32'h0);
      rd(5'h04, d); chk("R1 status", d, 32'h0);
      rd(5'h10, d); chk("R1 mask", d, 32'h0);
      rd(5'h08, d); chk("R1 data", d, 32'h0);

      // R10 warm load held while disabled, entropy ignored
      wr(5'h04, 32'hFFF0_0005);
      rd(5'h04, d); chk("R3 R5 warm readback", d, 32'h0000_0005);
      send_bits(32'hFFFF_FFFF, 40);
      rd(5'h04, d); chk("R10 warm held off", d, 32'h0000_0005);

      // R2 enable, upper bits ignored
      wr(5'h00, 32'hFFFF_FFFF);
      rd(5'h00, d); chk("R2 ctrl readback", d, 32'h1);
      send_bits(32'h0000_0007, 3);
      rd(5'h04, d); chk("R3 warm decrement", d, 32'h0000_0002);
      send_bits(32'h3, 2);
      rd(5'h04, d); chk("R3 warm zero", d, 32'h0);

      // R4 R5 R6 three words
      for (int k = 0; k < 3; k++) send_word(w);
      rd(5'h04, d); chk("R5 count 3", d, 32'h0300_0000);
      chk("R11 irq set", {31'b0, data_irq}, 32'h1);
      drain("R4 R6 word order");
      rd(5'h04, d); chk("R5 count 0", d, 32'h0);
      chk("R11 irq clear", {31'b0, data_irq}, 32'h0);

      // R7 empty read
      rd(5'h08, d); chk("R7 empty data", d, 32'h0);
      rd(5'h04, d); chk("R7 count kept", d, 32'h0);

      // R11 mask
      wr(5'h10, 32'h1);
      rd(5'h10, d); chk("R11 mask readback", d, 32'h1);
      send_word(w);
      chk("R11 irq masked", {31'b0, data_irq}, 32'h0);
      wr(5'h10, 32'h0);
      chk("R11 irq unmasked", {31'b0, data_irq}, 32'h1);
      drain("R6 after mask");

      // R8 overfill
      for (int k = 0; k < 19; k++) send_word(w);
      rd(5'h04, d); chk("R8 count saturates", d, 32'h1000_0000);
      drain("R8 oldest kept");
      rd(5'h08, d); chk("R8 R7 empty after drain", d, 32'h0);

      // R9 flush with queued word and partial word
      send_word(w);
      send_bits(32'h3FF, 10);
      wr(5'h00, 32'h0);
      rd(5'h04, d); chk("R9 flushed", d, 32'h0);
      chk("R9 irq low", {31'b0, data_irq}, 32'h0);
      wr(5'h00, 32'h1);
      send_word(w);
      drain("R9 partial discarded");

      // R3 R4 warm-up sweep
      for (int wl = 0; wl < 7; wl++) begin
         wr(5'h00, 32'h0);
         wr(5'h04, wl);
         wr(5'h00, 32'h1);
         if (wl > 0) send_bits(32'hFFFF_FFFF, wl);
         rd(5'h04, d); chk("R3 sweep warm done", d, 32'h0);
         send_word(w);
         drain("R3 R4 sweep word");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule